// File: doc/BRIEF.md
# Serial Audio Transmitter with Clock Generation

This block sends stereo audio samples out over a three-wire serial link: a bit clock, a frame clock and one data line. A producer hands over one left/right sample pair at a time through a valid/ready handshake. The block shifts the pair out one frame later, MSB first. Data changes on the falling edge of the bit clock, so the receiver can latch it on the rising edge.

In clock-master role the block divides its system clock (the audio master clock) down to a bit clock and a frame clock. The master clock may be 128, 256, 384 or 512 times the sample rate. In this role the bit clock runs at 64 times the sample rate. In the wide multi-slot (TDM) master mode the bit clock runs at 256 times the sample rate, and the frame clock becomes a single-bit pulse. In clock-slave role the block keeps its own clock outputs low. It follows an external bit clock and frame clock, which it brings into the system clock domain through synchronizers. The system clock must be at least eight times the external bit clock.

The block supports three formats: left-justified, I2S-style (one bit of delay, left channel while the frame clock is low) and right-justified. Each takes word lengths of 16, 20, 24 or 32 bits. If no new pair has arrived when a frame starts, the last pair is sent again and an underflow flag is raised for that frame.

Top module: `sat_tx`

## Requirements
- R1: In master role with the multi-slot mode off, the bit clock period is 2, 4, 6 or 8 system clock cycles for `cfg_ratio` codes 0, 1, 2 and 3 (master clock of 128, 256, 384 and 512 times the sample rate). The bit clock is high for exactly half of each period.
- R2: In master role with `cfg_tdm`=1, the bit clock period is 2 system clock cycles whatever `cfg_ratio` holds. A frame is 256 bit clocks long. The frame clock is high only during the first bit of each frame.
- R3: `sdata_o` changes only on a falling edge of the bit clock. It is stable for the whole high phase.
- R4: Format code 0 (left-justified): the frame is 64 bits with bit 0 first. The frame clock is high for bits 0..31 (left) and low for bits 32..63 (right). Word length codes 0..3 mean W = 16, 20, 24 and 32. Samples are right-aligned in the 32-bit input words, and bits above W are ignored. Each channel sends its W bits MSB first, starting at the first bit of its half, followed by low bits.
- R5: Format code 1 (I2S-style): the data placement is as in R4. The frame clock is low for bits 63 and 0..30 and high for bits 31..62, so it changes one bit ahead of each half.
- R6: Format code 2 (right-justified): the frame clock is as in R4. Each channel's W bits end on the last bit of its half, and all earlier bits of the half are low.
- R7: In the multi-slot mode the left word fills slot 0 (bits 0..31) and the right word fills slot 1 (bits 32..63), each left-justified whatever `cfg_fmt` holds. Slots 2..7 are driven low.
- R8: `s_ready` is high while the holding register is empty. A pair is taken when `s_valid` and `s_ready` are both high. A taken pair is held unchanged until the next frame start, and no later offer overwrites it.
- R9: At a frame start with no pair held, the previous pair is sent again and `underflow_o` is 1 for that frame. A frame start with a pair held clears `underflow_o`.
- R10: In slave role (`cfg_master`=0), `bclk_o` and `fclk_o` stay low. Data advances on falling edges of `sclk_in`. A frame begins where `fclk_in` enters the left-channel level: high for codes 0 and 2, low for code 1, where that change marks bit 63.
- R11: While reset is held, `s_ready` is 1 and `bclk_o`, `fclk_o`, `sdata_o` and `underflow_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System / audio master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1: generate clocks, 0: follow external clocks |
| cfg_tdm | input | 1 | Multi-slot 256-bit frame (master role only) |
| cfg_fmt | input | 2 | Format: 0 left-justified, 1 I2S-style, 2 right-justified |
| cfg_wlen | input | 2 | Word length: 0=16, 1=20, 2=24, 3=32 bits |
| cfg_ratio | input | 2 | Master clock ratio: 0=128, 1=256, 2=384, 3=512 x sample rate |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding register empty |
| s_left | input | SLOT_W | Left sample, right-aligned |
| s_right | input | SLOT_W | Right sample, right-aligned |
| sclk_in | input | 1 | External bit clock (slave role) |
| fclk_in | input | 1 | External frame clock (slave role) |
| bclk_o | output | 1 | Generated bit clock |
| fclk_o | output | 1 | Generated frame clock |
| sdata_o | output | 1 | Serial data |
| underflow_o | output | 1 | Current frame repeats the previous pair |

## Verification
The main serializing function runs under three families of patterns, and each family separates a different kind of fault.

- **Master-role frames.** Each format is paired with a different word length and master clock ratio. Sample words carry bits above the word length, so a frame shows whether data is placed from the wrong end of a half, whether it uses the wrong length, or whether it leaks unused upper bits.
- **Slave-role frames.** These are driven by a bench-made bit clock and frame clock. Only correct frame-clock alignment lines a frame up with the expected bits, and the one-bit I2S offset is what tells I2S from left-justified.
- **Directed runs.** These time the divider at every ratio, where a wrong divisor or duty shows up as a wrong cycle count. A 256-bit multi-slot frame is loaded with right-justified format selected, which shows whether the format is ignored in that mode. A double offer followed by a starved frame separates holding-register overwrite from correct repetition and flagging.

// File: rtl/sat_pkg.sv
package sat_pkg;

  localparam logic [1:0] FMT_LJ  = 2'd0;
  localparam logic [1:0] FMT_I2S = 2'd1;
  localparam logic [1:0] FMT_RJ  = 2'd2;

  // word length code -> number of bits
  function automatic int unsigned wlen_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 16;
      2'd1:    return 20;
      2'd2:    return 24;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/sat_clkgen.sv
module sat_clkgen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       master,
  input  logic       tdm,
  input  logic [1:0] ratio,
  input  logic       sclk_in,
  input  logic       fclk_in,
  output logic       tick,
  output logic       fclk_smp,
  output logic       bclk_o
);
  localparam int CW = 4;

  logic [CW-1:0]        div_cnt;
  logic [CW-1:0]        div_last;
  logic [CW-1:0]        div_half;
  logic                 bclk_q;
  logic [SYNC_STAGES:0] s_sh;
  logic [SYNC_STAGES-1:0] f_sh;
  logic                 ext_fall;

  // divisor - 1 : 1,3,5,7 in normal mode, 1 in multi-slot mode
  always_comb begin
    div_last = tdm ? CW'(1) : CW'({ratio, 1'b1});
    div_half = div_last >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
    end else if (!master) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
    end else if (div_cnt == div_last) begin
      div_cnt <= '0;
      bclk_q  <= 1'b0;
    end else begin
      div_cnt <= div_cnt + CW'(1);
      if (div_cnt == div_half) bclk_q <= 1'b1;
    end
  end

  // external clocks into the system domain
  always_ff @(posedge clk) begin
    if (rst) begin
      s_sh <= '0;
      f_sh <= '0;
    end else begin
      s_sh <= {s_sh[SYNC_STAGES-1:0], sclk_in};
      f_sh <= {f_sh[SYNC_STAGES-2:0], fclk_in};
    end
  end

  assign ext_fall = s_sh[SYNC_STAGES] & ~s_sh[SYNC_STAGES-1];
  assign fclk_smp = f_sh[SYNC_STAGES-1];
  assign tick     = master ? (div_cnt == div_last) : ext_fall;
  assign bclk_o   = bclk_q;

  // R1
  bclk_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (master && tick) |-> bclk_q);

endmodule

// File: rtl/sat_sample_buf.sv
module sat_sample_buf #(
  parameter int SLOT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [SLOT_W-1:0] s_left,
  input  logic [SLOT_W-1:0] s_right,
  input  logic              load,
  output logic [SLOT_W-1:0] frm_l,
  output logic [SLOT_W-1:0] frm_r,
  output logic              underflow
);
  logic              pend_v;
  logic [SLOT_W-1:0] pend_l, pend_r;
  logic [SLOT_W-1:0] act_l, act_r;
  logic [SLOT_W-1:0] nxt_l, nxt_r;
  logic              under_q;

  assign s_ready = ~pend_v;
  assign nxt_l   = pend_v ? pend_l : act_l;
  assign nxt_r   = pend_v ? pend_r : act_r;
  assign frm_l   = load ? nxt_l : act_l;
  assign frm_r   = load ? nxt_r : act_r;
  assign underflow = under_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v  <= 1'b0;
      pend_l  <= '0;
      pend_r  <= '0;
      act_l   <= '0;
      act_r   <= '0;
      under_q <= 1'b0;
    end else begin
      if (load) begin
        act_l   <= nxt_l;
        act_r   <= nxt_r;
        under_q <= ~pend_v;
        pend_v  <= 1'b0;
      end
      if (s_valid && s_ready) begin
        pend_l <= s_left;
        pend_r <= s_right;
        pend_v <= 1'b1;
      end
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_v && !load) |=> (pend_v && $stable(pend_l) && $stable(pend_r)));

  // R9
  repeat_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !pend_v) |=> (under_q && $stable(act_l) && $stable(act_r)));

endmodule

// File: rtl/sat_serializer.sv
module sat_serializer #(
  parameter int SLOT_W    = 32,
  parameter int TDM_SLOTS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master,
  input  logic              tdm,
  input  logic [1:0]        fmt,
  input  logic [1:0]        wlen,
  input  logic              tick,
  input  logic              fclk_smp,
  input  logic [SLOT_W-1:0] frm_l,
  input  logic [SLOT_W-1:0] frm_r,
  output logic              load,
  output logic              sdata_o,
  output logic              fclk_o
);
  import sat_pkg::*;

  localparam int POS_W  = $clog2(SLOT_W);
  localparam int IDX_W  = $clog2(SLOT_W * TDM_SLOTS);
  localparam int WB_W   = POS_W + 1;
  localparam int SL_W   = IDX_W - POS_W;
  localparam logic [IDX_W-1:0] NORM_LAST = IDX_W'(2 * SLOT_W - 1);
  localparam logic [IDX_W-1:0] TDM_LAST  = IDX_W'(SLOT_W * TDM_SLOTS - 1);

  logic [IDX_W-1:0] idx, nidx, last, inc, nidx_p1;
  logic             tdm_on, is_i2s, is_rj, left_lvl, start, prev_f;
  logic [SL_W-1:0]  slot;
  logic [POS_W-1:0] pos, bi;
  logic [WB_W-1:0]  pos_x, wb;
  logic [SLOT_W-1:0] word;
  logic             bit_n, fclk_n, in_use;
  logic             sdata_q, fclk_q;

  assign tdm_on   = tdm && master;
  assign is_i2s   = (fmt == FMT_I2S);
  assign is_rj    = (fmt == FMT_RJ);
  assign left_lvl = ~is_i2s;

  // frame position sequencing
  always_comb begin
    last  = tdm_on ? TDM_LAST : NORM_LAST;
    inc   = (idx >= last) ? '0 : idx + IDX_W'(1);
    start = !master && (fclk_smp == left_lvl) && (prev_f != left_lvl);
    if (start) nidx = is_i2s ? NORM_LAST : '0;
    else       nidx = inc;
  end

  assign load = tick && (nidx == '0);

  // bit selection for the upcoming position
  always_comb begin
    slot   = nidx[IDX_W-1:POS_W];
    pos    = nidx[POS_W-1:0];
    pos_x  = {1'b0, pos};
    wb     = WB_W'(wlen_bits(wlen));
    word   = (slot == '0) ? frm_l : frm_r;
    in_use = tdm_on ? (slot < SL_W'(2)) : 1'b1;
    bi     = '0;
    bit_n  = 1'b0;
    if (in_use) begin
      if (!tdm_on && is_rj) begin
        if (pos_x >= (WB_W'(SLOT_W) - wb)) begin
          bi    = POS_W'(SLOT_W - 1) - pos;
          bit_n = word[bi];
        end
      end else if (pos_x < wb) begin
        bi    = POS_W'(wb - WB_W'(1) - pos_x);
        bit_n = word[bi];
      end
    end
  end

  // frame clock level for the upcoming position
  always_comb begin
    nidx_p1 = nidx + IDX_W'(1);
    if (tdm_on)      fclk_n = (nidx == '0);
    else if (is_i2s) fclk_n = nidx_p1[POS_W];
    else             fclk_n = ~nidx[POS_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '1;
      prev_f  <= 1'b0;
      sdata_q <= 1'b0;
      fclk_q  <= 1'b0;
    end else if (tick) begin
      idx     <= nidx;
      prev_f  <= fclk_smp;
      sdata_q <= bit_n;
      fclk_q  <= master ? fclk_n : 1'b0;
    end
  end

  assign sdata_o = sdata_q;
  assign fclk_o  = fclk_q;

  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sdata_q));

  // R2
  tdm_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (tdm_on && tick && fclk_q) |=> !fclk_q);

  // R5
  i2s_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (master && !tdm && is_i2s && $rose(fclk_q)) |-> (idx == IDX_W'(SLOT_W - 1)));

endmodule

// File: rtl/sat_tx.sv
module sat_tx #(
  parameter int SLOT_W      = 32,
  parameter int TDM_SLOTS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_master,
  input  logic              cfg_tdm,
  input  logic [1:0]        cfg_fmt,
  input  logic [1:0]        cfg_wlen,
  input  logic [1:0]        cfg_ratio,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [SLOT_W-1:0] s_left,
  input  logic [SLOT_W-1:0] s_right,
  input  logic              sclk_in,
  input  logic              fclk_in,
  output logic              bclk_o,
  output logic              fclk_o,
  output logic              sdata_o,
  output logic              underflow_o
);
  logic              tick, fclk_smp, load;
  logic [SLOT_W-1:0] frm_l, frm_r;

  sat_clkgen #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk(clk), .rst(rst), .master(cfg_master), .tdm(cfg_tdm),
    .ratio(cfg_ratio), .sclk_in(sclk_in), .fclk_in(fclk_in),
    .tick(tick), .fclk_smp(fclk_smp), .bclk_o(bclk_o)
  );

  sat_sample_buf #(.SLOT_W(SLOT_W)) u_buf (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_left(s_left), .s_right(s_right), .load(load),
    .frm_l(frm_l), .frm_r(frm_r), .underflow(underflow_o)
  );

  sat_serializer #(.SLOT_W(SLOT_W), .TDM_SLOTS(TDM_SLOTS)) u_ser (
    .clk(clk), .rst(rst), .master(cfg_master), .tdm(cfg_tdm),
    .fmt(cfg_fmt), .wlen(cfg_wlen), .tick(tick), .fclk_smp(fclk_smp),
    .frm_l(frm_l), .frm_r(frm_r), .load(load),
    .sdata_o(sdata_o), .fclk_o(fclk_o)
  );

  // R10
  slave_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_master |-> (!bclk_o && !fclk_o));

endmodule

// File: tb/tb_sat_tx.sv
`timescale 1ns/1ps
module tb_sat_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_master = 1'b1, cfg_tdm = 1'b0;
  logic [1:0] cfg_fmt = '0, cfg_wlen = '0, cfg_ratio = '0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [31:0] s_left = '0, s_right = '0;
  logic sclk_in = 1'b1, fclk_in = 1'b0;
  logic bclk_o, fclk_o, sdata_o, underflow_o;

  int n_tests = 0, n_fail = 0, cyc = 0, rise_cnt = 0;
  bit done = 0;
  logic [255:0] got_d, got_f, exp_d, exp_f;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge bclk_o or posedge rst)
    if (rst) rise_cnt <= 0; else rise_cnt <= rise_cnt + 1;

  sat_tx dut (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_tdm(cfg_tdm),
    .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_ratio(cfg_ratio),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .sclk_in(sclk_in), .fclk_in(fclk_in), .bclk_o(bclk_o), .fclk_o(fclk_o),
    .sdata_o(sdata_o), .underflow_o(underflow_o)
  );

  typedef struct packed {
    logic        master;
    logic [1:0]  fmt;
    logic [1:0]  wl;
    logic [1:0]  ratio;
    logic [31:0] l;
    logic [31:0] r;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 2'd0, 2'd0, 2'd0, 32'hFFFF_A5C3, 32'h0000_1E7F},
    '{1'b1, 2'd1, 2'd2, 2'd1, 32'hFF9A_B3C1, 32'h004D_2E17},
    '{1'b1, 2'd2, 2'd1, 2'd3, 32'hABC8_F0E1, 32'h0003_C5A9},
    '{1'b1, 2'd0, 2'd3, 2'd2, 32'hC001_D00D, 32'h1234_5678},
    '{1'b0, 2'd1, 2'd0, 2'd0, 32'h5555_8001, 32'h0000_7FFE},
    '{1'b0, 2'd2, 2'd2, 2'd0, 32'hEE81_4C3B, 32'h00F0_0F0F},
    '{1'b0, 2'd0, 2'd3, 2'd0, 32'h8765_4321, 32'hDEAD_BEEF}
  };

  task automatic chk(input string req, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic ex_bit(input logic tdm, input logic [1:0] fmt,
                                  input logic [1:0] wl, input int idx,
                                  input logic [31:0] l, input logic [31:0] r);
    int w, slot, p;
    logic [31:0] word;
    w = (wl == 0) ? 16 : (wl == 1) ? 20 : (wl == 2) ? 24 : 32;
    slot = idx / 32;
    p = idx % 32;
    if (slot > 1) return 1'b0;
    word = (slot == 0) ? l : r;
    if (!tdm && fmt == 2) return (p >= 32 - w) ? word[31 - p] : 1'b0;
    return (p < w) ? word[w - 1 - p] : 1'b0;
  endfunction

  function automatic logic ex_fclk(input logic tdm, input logic [1:0] fmt, input int idx);
    if (tdm) return idx == 0;
    if (fmt == 1) return ((idx + 1) % 64) >= 32;
    return idx < 32;
  endfunction

  function automatic string req_of(input logic [1:0] fmt);
    if (fmt == 1) return "R5";
    if (fmt == 2) return "R6";
    return "R4";
  endfunction

  task automatic do_reset(input logic m, input logic t, input logic [1:0] f,
                          input logic [1:0] w, input logic [1:0] ra);
    @(negedge clk);
    rst = 1'b1;
    cfg_master = m; cfg_tdm = t; cfg_fmt = f; cfg_wlen = w; cfg_ratio = ra;
    s_valid = 1'b0; sclk_in = 1'b1; fclk_in = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push(input logic [31:0] l, input logic [31:0] r);
    @(negedge clk);
    s_valid = 1'b1; s_left = l; s_right = r;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // capture frame fr of length flen, counting bit-clock rises since reset
  task automatic grab_master(input int fr, input int flen);
    got_d = '0; got_f = '0;
    for (int i = 0; i < flen; i++) begin
      while (rise_cnt < 2 + fr * flen + i) @(negedge clk);
      got_d[i] = sdata_o;
      got_f[i] = fclk_o;
    end
  endtask

  task automatic run_slave(input logic [1:0] fmt, input int nfr, input int cap);
    got_d = '0;
    for (int fr = 0; fr < nfr; fr++)
      for (int j = 0; j < 64; j++) begin
        @(negedge clk);
        sclk_in = 1'b0;
        fclk_in = ex_fclk(1'b0, fmt, j);
        repeat (8) @(negedge clk);
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
        if (fr == cap) got_d[j] = sdata_o;
        repeat (3) @(negedge clk);
      end
  endtask

  task automatic measure(input logic t, input logic [1:0] ra, input string req,
                         input int exp_per);
    int c1, c2, hi;
    do_reset(1'b1, t, 2'd0, 2'd0, ra);
    while (rise_cnt < 2) @(negedge clk);
    c1 = cyc;
    while (rise_cnt < 3) @(negedge clk);
    c2 = cyc;
    hi = 0;
    while (bclk_o) begin hi++; @(negedge clk); end
    chk(req, "bit clock period", 256'(c2 - c1), 256'(exp_per));
    chk(req, "bit clock high time", 256'(hi), 256'(exp_per / 2));
  endtask

  initial begin
    // R11: reset state
    do_reset(1'b1, 1'b0, 2'd0, 2'd0, 2'd0);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "s_ready in reset", 256'(s_ready), 256'(1));
    chk("R11", "bclk_o in reset", 256'(bclk_o), 256'(0));
    chk("R11", "fclk_o in reset", 256'(fclk_o), 256'(0));
    chk("R11", "sdata_o in reset", 256'(sdata_o), 256'(0));
    chk("R11", "underflow_o in reset", 256'(underflow_o), 256'(0));

    // table of format / length / ratio / role vectors
    for (int v = 0; v < 7; v++) begin
      exp_d = '0; exp_f = '0;
      for (int i = 0; i < 64; i++) begin
        exp_d[i] = ex_bit(1'b0, VECS[v].fmt, VECS[v].wl, i, VECS[v].l, VECS[v].r);
        exp_f[i] = ex_fclk(1'b0, VECS[v].fmt, i);
      end
      if (VECS[v].master) begin
        do_reset(1'b1, 1'b0, VECS[v].fmt, VECS[v].wl, VECS[v].ratio);
        repeat (8) @(negedge clk);
        push(VECS[v].l, VECS[v].r);
        grab_master(1, 64);
        chk(req_of(VECS[v].fmt), $sformatf("vec %0d data", v), got_d, exp_d);
        chk(req_of(VECS[v].fmt), $sformatf("vec %0d frame clock", v), got_f, exp_f);
      end else begin
        do_reset(1'b0, 1'b0, VECS[v].fmt, VECS[v].wl, 2'd0);
        push(VECS[v].l, VECS[v].r);
        run_slave(VECS[v].fmt, 3, 2);
        chk({"R10 ", req_of(VECS[v].fmt)}, $sformatf("vec %0d slave data", v), got_d, exp_d);
        chk("R10", "clock outputs low in slave", 256'({bclk_o, fclk_o}), 256'(0));
      end
    end

    // R1: divider for every ratio; R2: fixed divider in multi-slot mode
    for (int ra = 0; ra < 4; ra++) measure(1'b0, 2'(ra), "R1", 2 * (ra + 1));
    measure(1'b1, 2'd3, "R2", 2);

    // R2 / R7: multi-slot frame, format code RJ must be ignored
    do_reset(1'b1, 1'b1, 2'd2, 2'd2, 2'd1);
    repeat (8) @(negedge clk);
    push(32'h7FA1_B2C3, 32'h0081_0F55);
    grab_master(1, 256);
    exp_d = '0; exp_f = '0;
    for (int i = 0; i < 256; i++) begin
      exp_d[i] = ex_bit(1'b1, 2'd2, 2'd2, i, 32'h7FA1_B2C3, 32'h0081_0F55);
      exp_f[i] = ex_fclk(1'b1, 2'd2, i);
    end
    chk("R7", "multi-slot data", got_d, exp_d);
    chk("R2", "multi-slot frame pulse", got_f, exp_f);

    // R8 / R9: handshake, no overwrite, repetition with underflow
    do_reset(1'b1, 1'b0, 2'd0, 2'd3, 2'd0);
    repeat (4) @(negedge clk);
    chk("R9", "underflow on starved first frame", 256'(underflow_o), 256'(1));
    repeat (4) @(negedge clk);
    push(32'h1357_9BDF, 32'h2468_ACE0);
    chk("R8", "s_ready low while holding", 256'(s_ready), 256'(0));
    s_valid = 1'b1; s_left = 32'hFFFF_FFFF; s_right = 32'hFFFF_FFFF;
    repeat (6) @(negedge clk);
    s_valid = 1'b0;
    exp_d = '0;
    for (int i = 0; i < 64; i++)
      exp_d[i] = ex_bit(1'b0, 2'd0, 2'd3, i, 32'h1357_9BDF, 32'h2468_ACE0);
    grab_master(1, 64);
    chk("R8", "held pair not overwritten", got_d, exp_d);
    chk("R9", "underflow clear with new pair", 256'(underflow_o), 256'(0));
    grab_master(2, 64);
    chk("R9", "starved frame repeats pair", got_d, exp_d);
    chk("R9", "underflow set on repeat", 256'(underflow_o), 256'(1));
    chk("R8", "s_ready high when empty", 256'(s_ready), 256'(1));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule